// File: doc/BRIEF.md
# Looping Audio DMA Frame Counter Engine

This block does the position and interrupt bookkeeping for one channel of a circular audio DMA buffer. The buffer is described by a frame register. Its upper half is the current 32-bit word index. Its lower half is the index of the last word in the buffer. Because the position is kept in words, a 2-bit byte remainder records how far into the current word the stream has gone. A sample register counts down the samples still to go before an end-of-block interrupt; its lower half is the value the countdown reloads from. The block does not move any data. It only sizes each burst and keeps the counters, the next byte address and the interrupt state up to date.

A client offers a burst length in bytes through a valid/ready handshake. A sequencer with two states, `ST_IDLE` and `ST_APPLY`, handles it:
- The accept transition (`ST_IDLE` to `ST_APPLY`, taken when `req_valid` is high) captures the offer.
- The commit transition (`ST_APPLY` back to `ST_IDLE`, taken unconditionally) writes the new counters.
- On the cycle after the commit, `done_valid` pulses together with the number of bytes moved, a possible interrupt pulse and a possible lost-interrupt pulse.

Counter loads from the control side are taken only while the engine is in `ST_IDLE`.

Top module: `audio_dma_frame_engine`

## Requirements
- R1: After reset the frame and sample registers and the byte remainder are zero, no interrupt is pending, `req_ready` is high and `done_valid` is low.
- R2: The 2-bit format code sets the byte shift per sample.
  - Bit 0 set means stereo and bit 1 set means 16-bit, and the shift is bit 0 plus bit 1.
  - The offered byte count is rounded down to a whole number of samples.
  - An offer that rounds to zero moves nothing and leaves every counter unchanged.
- R3: A burst moves the smallest of three amounts:
  - the rounded offer;
  - the bytes left in the buffer, which is ((last index − current index + 1) × 4) + remainder;
  - the bytes left before the interrupt, which is (sample countdown + 1) shifted left by the byte shift.
- R4: When a burst uses up exactly the bytes left before the interrupt, the countdown (upper half of `samp_cnt`) reloads from the reload half. Otherwise it becomes (bytes left before the interrupt − moved − 1) shifted right by the byte shift.
- R5: After a burst the word index advances by (moved + remainder) / 4, and the remainder becomes (moved + remainder) mod 4.
  - With `cfg_wrap` high, an index that would exceed the last index becomes 0.
  - With `cfg_wrap` low, the index is left as it was.
- R6: `next_addr` always equals `cfg_base` + current index × 4 + remainder.
- R7: Nothing moves and no counter changes in any of these cases: `cfg_enable` is low, `cfg_pause` is high, or the last index is below the current index.
- R8: A reload with `cfg_irq_en` high gives a one-cycle `irq_pulse`. If `irq_pending` was already set, `lost_pulse` is raised as well.
- R9: `irq_pending` is set by an interrupt. It is cleared by `irq_ack`, or when `cfg_irq_en` falls from 1 to 0. A set and an acknowledge that fall in the same cycle leave it set.
- R10: After an offer is accepted, `req_ready` is low for exactly one cycle. The updated counters and `done_valid` appear on the following cycle.
- R11: Loads are taken only in `ST_IDLE`. A load requested during `ST_APPLY` is ignored.
  - `ld_frame` writes the index (upper half) and the last index (lower half), and clears the remainder.
  - `ld_samp` writes its value into both halves of the sample register.
  - A load accepted in the same cycle as an offer is applied before that burst is sized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_pause | input | 1 | Channel pause (tie low for a channel without pause) |
| cfg_wrap | input | 1 | 1 = loop the buffer, 0 = hold the index |
| cfg_irq_en | input | 1 | End-of-block interrupt enable |
| cfg_fmt | input | 2 | Format: bit 0 stereo, bit 1 16-bit |
| cfg_base | input | ADDR_W | Buffer base byte address |
| ld_frame | input | 1 | Load the frame register |
| ld_frame_val | input | 2*IDX_W | {index, last index} |
| ld_samp | input | 1 | Load the sample register |
| ld_samp_val | input | IDX_W | Countdown and reload value |
| irq_ack | input | 1 | Clear the pending interrupt |
| req_valid | input | 1 | Burst offer valid |
| req_bytes | input | LEN_W | Bytes offered |
| req_ready | output | 1 | Engine idle and able to take an offer |
| done_valid | output | 1 | One-cycle pulse when a burst result is shown |
| xfer_bytes | output | CW | Bytes moved by that burst |
| frame_cnt | output | 2*IDX_W | {index, last index} |
| samp_cnt | output | 2*IDX_W | {countdown, reload} |
| byte_rem | output | 2 | Sub-word byte remainder |
| next_addr | output | ADDR_W | Byte address for the next transfer |
| irq_pulse | output | 1 | End-of-block interrupt pulse |
| lost_pulse | output | 1 | Interrupt raised while one was already pending |
| irq_pending | output | 1 | Interrupt pending flag |

## Verification
Two pairs of events can meet in a single cycle.

The first pair is a counter load and a burst offer. The bench asserts `ld_frame` in the same idle cycle that it offers a burst, and expects the burst to be sized from the freshly loaded index. It also raises a load during `ST_APPLY` and expects that load to leave no trace.

The second pair is an interrupt being set and being acknowledged. The bench holds `irq_ack` high during the commit cycle of a burst that reloads the countdown. It expects `irq_pending` to stay set, and expects `lost_pulse` whenever the flag was already set before that burst.

// File: rtl/afe_pkg.sv
package afe_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } eng_state_e;

    // bytes per sample = 1 << shift; stereo and 16-bit each add one
    function automatic logic [1:0] fmt_shift(input logic [1:0] fmt);
        return {1'b0, fmt[0]} + {1'b0, fmt[1]};
    endfunction

endpackage

// File: rtl/afe_burst_sizer.sv
module afe_burst_sizer
    import afe_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int LEN_W = 16,
    parameter int CW    = 19
) (
    input  logic             chan_on,
    input  logic [1:0]       fmt,
    input  logic [LEN_W-1:0] offered,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last,
    input  logic [1:0]       rem,
    input  logic [IDX_W-1:0] countdown,
    output logic [1:0]       shift,
    output logic [CW-1:0]    irq_bytes,
    output logic [CW-1:0]    xfer,
    output logic             go,
    output logic             hit
);
    logic [CW-1:0] mask;
    logic [CW-1:0] rounded;
    logic [CW-1:0] room;

    always_comb begin
        shift     = fmt_shift(fmt);
        mask      = ~((CW'(1) << shift) - CW'(1));
        rounded   = CW'(offered) & mask;
        room      = ((CW'(last) - CW'(idx) + CW'(1)) << 2) + CW'(rem);
        irq_bytes = (CW'(countdown) + CW'(1)) << shift;
        go        = chan_on && (rounded != '0) && (last >= idx);
        xfer      = rounded;
        if (room < xfer) begin
            xfer = room;
        end
        if (irq_bytes < xfer) begin
            xfer = irq_bytes;
        end
        if (!go) begin
            xfer = '0;
        end
        hit = go && (xfer == irq_bytes);
    end

endmodule

// File: rtl/afe_count_update.sv
module afe_count_update #(
    parameter int IDX_W = 16,
    parameter int CW    = 19
) (
    input  logic [CW-1:0]    xfer,
    input  logic [CW-1:0]    irq_bytes,
    input  logic             hit,
    input  logic [1:0]       shift,
    input  logic             wrap,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last,
    input  logic [1:0]       rem,
    input  logic [IDX_W-1:0] reload,
    output logic [IDX_W-1:0] new_idx,
    output logic [1:0]       new_rem,
    output logic [IDX_W-1:0] new_countdown
);
    logic [CW-1:0] sum;
    logic [CW-1:0] adv;
    logic [CW-1:0] left_after;

    always_comb begin
        sum     = xfer + CW'(rem);
        adv     = CW'(idx) + (sum >> 2);
        new_rem = sum[1:0];
        if (wrap) begin
            new_idx = (adv <= CW'(last)) ? adv[IDX_W-1:0] : '0;
        end else begin
            new_idx = idx;
        end
        left_after = irq_bytes - xfer - CW'(1);
        if (hit) begin
            new_countdown = reload;
        end else begin
            new_countdown = IDX_W'(left_after >> shift);
        end
    end

endmodule

// File: rtl/afe_addr_gen.sv
module afe_addr_gen #(
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        rem,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = base + (ADDR_W'(idx) << 2) + ADDR_W'(rem);
    end

endmodule

// File: rtl/audio_dma_frame_engine.sv
module audio_dma_frame_engine
    import afe_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    localparam int CW    = (LEN_W > IDX_W + 3) ? LEN_W : IDX_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_pause,
    input  logic               cfg_wrap,
    input  logic               cfg_irq_en,
    input  logic [1:0]         cfg_fmt,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic               ld_frame,
    input  logic [2*IDX_W-1:0] ld_frame_val,
    input  logic               ld_samp,
    input  logic [IDX_W-1:0]   ld_samp_val,
    input  logic               irq_ack,
    input  logic               req_valid,
    input  logic [LEN_W-1:0]   req_bytes,
    output logic               req_ready,
    output logic               done_valid,
    output logic [CW-1:0]      xfer_bytes,
    output logic [2*IDX_W-1:0] frame_cnt,
    output logic [2*IDX_W-1:0] samp_cnt,
    output logic [1:0]         byte_rem,
    output logic [ADDR_W-1:0]  next_addr,
    output logic               irq_pulse,
    output logic               lost_pulse,
    output logic               irq_pending
);
    eng_state_e state_q, state_d;

    logic [IDX_W-1:0] idx_q, last_q, cdown_q, reload_q;
    logic [1:0]       rem_q;
    logic [LEN_W-1:0] offer_q;
    logic             pending_q, irq_en_q;
    logic             done_q, irq_q, lost_q;
    logic [CW-1:0]    xfer_q;

    logic             accept, commit, chan_on, irq_set;
    logic [1:0]       shift;
    logic [CW-1:0]    irq_bytes, xfer_w;
    logic             go, hit;
    logic [IDX_W-1:0] new_idx, new_cdown;
    logic [1:0]       new_rem;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept (IDLE->APPLY), commit (APPLY->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state-decoded controls
    always_comb begin
        req_ready = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_APPLY: commit    = 1'b1;
            default:  req_ready = 1'b0;
        endcase
        accept  = req_valid && req_ready;
        chan_on = cfg_enable && !cfg_pause;
        irq_set = hit && cfg_irq_en;
    end

    afe_burst_sizer #(.IDX_W(IDX_W), .LEN_W(LEN_W), .CW(CW)) u_sizer (
        .chan_on   (chan_on),
        .fmt       (cfg_fmt),
        .offered   (offer_q),
        .idx       (idx_q),
        .last      (last_q),
        .rem       (rem_q),
        .countdown (cdown_q),
        .shift     (shift),
        .irq_bytes (irq_bytes),
        .xfer      (xfer_w),
        .go        (go),
        .hit       (hit)
    );

    afe_count_update #(.IDX_W(IDX_W), .CW(CW)) u_update (
        .xfer          (xfer_w),
        .irq_bytes     (irq_bytes),
        .hit           (hit),
        .shift         (shift),
        .wrap          (cfg_wrap),
        .idx           (idx_q),
        .last          (last_q),
        .rem           (rem_q),
        .reload        (reload_q),
        .new_idx       (new_idx),
        .new_rem       (new_rem),
        .new_countdown (new_cdown)
    );

    afe_addr_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_addr (
        .base (cfg_base),
        .idx  (idx_q),
        .rem  (rem_q),
        .addr (next_addr)
    );

    // counters, interrupt state and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            last_q    <= '0;
            cdown_q   <= '0;
            reload_q  <= '0;
            rem_q     <= '0;
            offer_q   <= '0;
            pending_q <= 1'b0;
            irq_en_q  <= 1'b0;
            done_q    <= 1'b0;
            irq_q     <= 1'b0;
            lost_q    <= 1'b0;
            xfer_q    <= '0;
        end else begin
            irq_en_q  <= cfg_irq_en;
            done_q    <= commit;
            irq_q     <= commit && irq_set;
            lost_q    <= commit && irq_set && pending_q;
            xfer_q    <= commit ? xfer_w : '0;
            pending_q <= (pending_q && !irq_ack && !(irq_en_q && !cfg_irq_en))
                         || (commit && irq_set);
            if (accept) begin
                offer_q <= req_bytes;
            end
            if (commit) begin
                if (go) begin
                    idx_q   <= new_idx;
                    rem_q   <= new_rem;
                    cdown_q <= new_cdown;
                end
            end else begin
                if (ld_frame) begin
                    idx_q  <= ld_frame_val[2*IDX_W-1:IDX_W];
                    last_q <= ld_frame_val[IDX_W-1:0];
                    rem_q  <= '0;
                end
                if (ld_samp) begin
                    cdown_q  <= ld_samp_val;
                    reload_q <= ld_samp_val;
                end
            end
        end
    end

    always_comb begin
        done_valid  = done_q;
        xfer_bytes  = xfer_q;
        frame_cnt   = {idx_q, last_q};
        samp_cnt    = {cdown_q, reload_q};
        byte_rem    = rem_q;
        irq_pulse   = irq_q;
        lost_pulse  = lost_q;
        irq_pending = pending_q;
    end

endmodule

// File: rtl/afe_checker.sv
module afe_checker #(
    parameter int IDX_W  = 16,
    parameter int LEN_W  = 16,
    localparam int CW    = (LEN_W > IDX_W + 3) ? LEN_W : IDX_W + 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               done_valid,
    input logic [CW-1:0]      xfer_bytes,
    input logic [2*IDX_W-1:0] frame_cnt,
    input logic [2*IDX_W-1:0] samp_cnt,
    input logic               irq_pulse,
    input logic               lost_pulse,
    input logic               irq_pending
);
    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 done_valid);

    // R4
    reload_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (samp_cnt[2*IDX_W-1:IDX_W] == samp_cnt[IDX_W-1:0]));

    // R8
    lost_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_pulse |-> (irq_pulse && done_valid));

    // R9
    irq_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_pending);

    // R7
    idle_burst_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && xfer_bytes == '0) |-> ($stable(frame_cnt) && $stable(samp_cnt)));

endmodule

bind audio_dma_frame_engine afe_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_afe_chk (.*);

// File: tb/audio_dma_frame_engine_test.sv
module audio_dma_frame_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 16;
    localparam int LEN_W  = 16;
    localparam int ADDR_W = 32;
    localparam int CW     = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1, cfg_pause = 1'b0, cfg_wrap = 1'b1, cfg_irq_en = 1'b1;
    logic [1:0] cfg_fmt = 2'd3;
    logic [ADDR_W-1:0] cfg_base = 32'h0001_0000;
    logic ld_frame = 1'b0, ld_samp = 1'b0, irq_ack = 1'b0, req_valid = 1'b0;
    logic [2*IDX_W-1:0] ld_frame_val = '0;
    logic [IDX_W-1:0] ld_samp_val = '0;
    logic [LEN_W-1:0] req_bytes = '0;
    logic req_ready, done_valid, irq_pulse, lost_pulse, irq_pending;
    logic [CW-1:0] xfer_bytes;
    logic [2*IDX_W-1:0] frame_cnt, samp_cnt;
    logic [1:0] byte_rem;
    logic [ADDR_W-1:0] next_addr;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int m_idx = 0, m_last = 0, m_cd = 0, m_rl = 0, m_rem = 0;
    bit m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_dma_frame_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr();
        return cfg_base + 32'(m_idx * 4 + m_rem);
    endfunction

    task automatic check_state(input string tag);
        check({tag, " R5 frame"}, 64'(frame_cnt), 64'({m_idx[15:0], m_last[15:0]}));
        check({tag, " R4 sample"}, 64'(samp_cnt), 64'({m_cd[15:0], m_rl[15:0]}));
        check({tag, " R5 rem"}, 64'(byte_rem), 64'(m_rem));
        check({tag, " R6 addr"}, 64'(next_addr), 64'(exp_addr()));
        check({tag, " R9 pending"}, 64'(irq_pending), 64'(m_pend));
    endtask

    // reference model of one burst
    task automatic model_burst(input int bytes, input bit ack, output int t, output bit irq, output bit lost);
        int sh, mb, left, cb, sum, adv;
        bit hit;
        sh = int'(cfg_fmt[0]) + int'(cfg_fmt[1]);
        t = 0; hit = 0;
        mb = bytes & ~((1 << sh) - 1);
        if (cfg_enable && !cfg_pause && mb != 0 && m_last >= m_idx) begin
            left = ((m_last - m_idx + 1) << 2) + m_rem;
            cb = (m_cd + 1) << sh;
            t = mb;
            if (left < t) t = left;
            if (cb < t) t = cb;
            hit = (t == cb);
            if (hit) m_cd = m_rl; else m_cd = (cb - t - 1) >> sh;
            sum = t + m_rem;
            adv = m_idx + (sum >> 2);
            if (cfg_wrap) m_idx = (adv <= m_last) ? adv : 0;
            m_rem = sum & 3;
        end
        irq = hit && cfg_irq_en;
        lost = irq && m_pend;
        if (ack) m_pend = 0;
        if (irq) m_pend = 1;
    endtask

    task automatic burst(input string tag, input int bytes, input bit ack_apply,
                         input bit ld_busy, input bit ld_now, input int li, input int ll);
        int t; bit irq, lost;
        @(negedge clk);
        req_valid = 1'b1;
        req_bytes = LEN_W'(bytes);
        if (ld_now) begin
            ld_frame = 1'b1;
            ld_frame_val = {li[15:0], ll[15:0]};
            m_idx = li; m_last = ll; m_rem = 0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        ld_frame = ld_busy;
        ld_frame_val = 32'h0003_0007;
        irq_ack = ack_apply;
        check({tag, " R10 busy"}, 64'(req_ready), 64'd0);
        model_burst(bytes, ack_apply, t, irq, lost);
        @(negedge clk);
        ld_frame = 1'b0;
        irq_ack = 1'b0;
        check({tag, " R10 done"}, 64'(done_valid), 64'd1);
        check({tag, " R3 xfer"}, 64'(xfer_bytes), 64'(t));
        check({tag, " R8 irq"}, 64'(irq_pulse), 64'(irq));
        check({tag, " R8 lost"}, 64'(lost_pulse), 64'(lost));
        check_state(tag);
    endtask

    task automatic load_frame(input int i, input int l);
        @(negedge clk);
        ld_frame = 1'b1; ld_frame_val = {i[15:0], l[15:0]};
        @(negedge clk);
        ld_frame = 1'b0;
        m_idx = i; m_last = l; m_rem = 0;
    endtask

    task automatic load_samp(input int v);
        @(negedge clk);
        ld_samp = 1'b1; ld_samp_val = v[15:0];
        @(negedge clk);
        ld_samp = 1'b0;
        m_cd = v; m_rl = v;
    endtask

    task automatic ack_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        m_pend = 0;
    endtask

    task automatic set_irq_en(input bit v);
        @(negedge clk);
        cfg_irq_en = v;
        @(negedge clk);
        if (!v) m_pend = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 frame", 64'(frame_cnt), 64'd0);
        check("R1 sample", 64'(samp_cnt), 64'd0);
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 pending", 64'(irq_pending), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", 64'(done_valid), 64'd0);
        check("R1 rem", 64'(byte_rem), 64'd0);

        // R3/R4: 16-bit stereo, countdown 3 -> 16 bytes to the interrupt
        cfg_fmt = 2'd3;
        load_frame(0, 9);
        load_samp(3);
        burst("R3 irq-limited", 100, 0, 0, 0, 0, 0);
        check("R5 direct idx", 64'(frame_cnt), 64'h0004_0009);
        check("R8 direct pend", 64'(irq_pending), 64'd1);
        // R2 rounding: 7 bytes at shift 2 -> 4
        burst("R2 round", 7, 0, 0, 0, 0, 0);
        check("R2 direct xfer", 64'(xfer_bytes), 64'd4);
        burst("R2 zero", 3, 0, 0, 0, 0, 0);
        // R8 lost: countdown is 2, 12 bytes reach the reload with pending set
        burst("R8 lost", 12, 0, 0, 0, 0, 0);
        ack_irq();
        // R7 gating
        cfg_enable = 1'b0;
        burst("R7 disabled", 40, 0, 0, 0, 0, 0);
        cfg_enable = 1'b1; cfg_pause = 1'b1;
        burst("R7 paused", 40, 0, 0, 0, 0, 0);
        cfg_pause = 1'b0;
        load_frame(5, 3);
        burst("R7 past end", 40, 0, 0, 0, 0, 0);
        // R5 wrap, 8-bit mono
        cfg_fmt = 2'd0;
        load_frame(0, 1);
        load_samp(100);
        burst("R5 wrap", 8, 0, 0, 0, 0, 0);
        check("R5 direct wrap", 64'(frame_cnt), 64'h0000_0001);
        burst("R5 rem3", 3, 0, 0, 0, 0, 0);
        burst("R5 rem carry", 2, 0, 0, 0, 0, 0);
        check("R5 direct rem", 64'(byte_rem), 64'd1);
        // R5 hold mode
        cfg_wrap = 1'b0;
        burst("R5 hold", 4, 0, 0, 0, 0, 0);
        cfg_wrap = 1'b1;
        // R9 set and ack in the same cycle
        cfg_fmt = 2'd1;
        load_frame(0, 20);
        load_samp(1);
        burst("R9 set+ack", 4, 1, 0, 0, 0, 0);
        check("R9 direct pend", 64'(irq_pending), 64'd1);
        set_irq_en(0);
        check("R9 enable fall", 64'(irq_pending), 64'd0);
        set_irq_en(1);
        // R11 load with offer same cycle, load during apply ignored
        burst("R11 load+offer", 6, 0, 0, 1, 2, 30);
        burst("R11 busy load", 4, 0, 1, 0, 0, 0);

        // constrained random phase
        for (int i = 0; i < 250; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) cfg_fmt = 2'($urandom % 4);
            if (r == 1) load_frame(int'($urandom % 24), int'($urandom % 20));
            if (r == 2) load_samp(int'($urandom % 40));
            if (r == 3) ack_irq();
            if (r == 4) cfg_wrap = ~cfg_wrap;
            burst("R3 random", int'($urandom % 300), ($urandom % 8) == 0,
                  ($urandom % 10) == 0, ($urandom % 12) == 0,
                  int'($urandom % 16), int'($urandom % 24));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule